// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the host-facing register file of a small Ethernet controller. The host reaches it through a 4-bit address, an 8-bit write port with a write strobe, and a combinational 8-bit read port. Offset 0 always reaches the command register. The two top bits of the command register choose a page, so the remaining fifteen offsets reach a different set of registers on each page. The block holds several kinds of state:

- receive-ring page pointers;
- transmit page and byte count;
- remote DMA address and count;
- receive and data configuration bytes;
- a six-byte station address and an eight-byte multicast filter.

It drives all of these to the datapath blocks.

The block also keeps the interrupt status and mask registers and drives one level-sensitive interrupt line. Frame transmission happens elsewhere. A transmit command only produces a one-cycle start pulse, and the block then waits for a completion strobe from the transmitter. A remote read or write command issued while the remote byte count is zero completes at once.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x01 and the interrupt status reads 0x80. Every ring, count, address, configuration and filter output is zero, and irq and tx_start are low.
- R2: Command bits 7:6 select the page. The register index is page*16 + addr, and address 0 reaches the command register on every page. Page 0 holds the ring start (1, write), ring stop (2, write), boundary (3), transmit page (4, write), transmit status (4, read), transmit count low/high (5/6, write), interrupt status (7), remote address low/high (8/9), remote count low/high (10/11, write), receive config (12, write), data config (14, write) and interrupt mask (15, write). Page 1 holds the station address at 1 to 6, the current page at 7 and the multicast filter at 8 to 15. Page 2 reads back the ring start at 1 and the ring stop at 2.
- R3: A command write with bit 0 (stop) clear removes status bit 7. A command write with bit 0 set leaves it. Status bit 7 never raises irq, whatever the mask.
- R4: A command write with bit 0 clear and bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 on the next cycle when the remote byte count is zero. It does not set it when the count is non-zero.
- R5: irq is high exactly when status bits 6:0 ANDed with mask bits 6:0 is non-zero.
- R6: Writing the status register clears each of bits 6:0 that is written as 1 and leaves bit 7 unchanged. A status bit set by an event in the same cycle stays set.
- R7: The transmit count, remote address and remote count are 16-bit values loaded by separate low-byte and high-byte writes. Each write leaves the other byte unchanged.
- R8: A command write with bit 0 clear and bit 2 set, while no transmit is pending, raises tx_start for exactly one cycle, the cycle after the write. Command bit 2 then reads 1 while the transmit is pending.
- R9: tx_done while a transmit is pending makes the transmit status read 0x01, sets status bit 1 and clears command bit 2. tx_done with nothing pending changes nothing.
- R10: On page 0, offsets 10 and 11 read the fixed identification bytes 0x50 and 0x43. Every location that is not readable reads 0x00.
- R11: Writes to the ring start or ring stop page are ignored when the value is above MEM_END_PG (0x80 by default). Writes to the boundary or current page are ignored when the value is at or above MEM_END_PG.
- R12: The page 1 station address and multicast registers read back what was written. Writes on page 3 change nothing, and reads on page 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for addr on the current page |
| irq | output | 1 | Level interrupt request |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_done | input | 1 | Transmit completion strobe |
| ring_start_pg | output | 8 | Receive ring first page |
| ring_stop_pg | output | 8 | Receive ring end page (exclusive) |
| ring_bnd_pg | output | 8 | Boundary page |
| ring_cur_pg | output | 8 | Current receive page |
| tx_page | output | 8 | Transmit buffer start page |
| tx_count | output | 16 | Transmit byte count |
| rmt_addr | output | 16 | Remote DMA start address |
| rmt_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |
| station_addr | output | 48 | Station address, byte i in bits 8i+7:8i |
| mcast_filter | output | 64 | Multicast filter, byte i in bits 8i+7:8i |

## Verification
The bench targets the limits of the page-range checks. Values exactly at the buffer end are accepted for the ring start and stop pages and refused for the boundary and current pages. A design with the comparisons swapped or shifted by one would keep the wrong value.

It checks that status bit 7 neither raises irq nor clears on a write of 1, and that a command write with the stop bit set leaves it in place. Sloppy masking would show up as a spurious interrupt or a lost reset flag.

It checks the zero-count remote transfer against a non-zero one, and a half-word write against the byte already loaded. It also checks the transmit handshake: a pulse exactly one cycle long, self-clearing of the command bit, and a stray completion with nothing pending. A design that let a page 3 write fall through would overwrite page 1 registers, and the read-back catches that.

// File: rtl/nic_regs_pkg.sv
// Shared constants for the paged NIC register file: register indices
// (page*16 + offset), command bit positions and status bit positions.
package nic_regs_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 2;
    localparam int IDX_W  = ADDR_W + PAGE_W;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [DATA_W-1:0] CMD_RESET = 8'h01;
    localparam logic [DATA_W-1:0] TX_OK_STS = 8'h01;
    localparam logic [DATA_W-1:0] ID_BYTE0  = 8'h50;
    localparam logic [DATA_W-1:0] ID_BYTE1  = 8'h43;

    // command bits
    localparam int CB_STOP = 0;
    localparam int CB_XMIT = 2;
    localparam int CB_RRD  = 3;
    localparam int CB_RWR  = 4;

    // interrupt status bits
    localparam int IB_TXOK = 1;
    localparam int IB_RDC  = 6;
    localparam int IB_RST  = 7;

    // register indices
    localparam logic [IDX_W-1:0] IX_RSTART = 6'h01;
    localparam logic [IDX_W-1:0] IX_RSTOP  = 6'h02;
    localparam logic [IDX_W-1:0] IX_BNDY   = 6'h03;
    localparam logic [IDX_W-1:0] IX_TXPG   = 6'h04;
    localparam logic [IDX_W-1:0] IX_TXCLO  = 6'h05;
    localparam logic [IDX_W-1:0] IX_TXCHI  = 6'h06;
    localparam logic [IDX_W-1:0] IX_ISTAT  = 6'h07;
    localparam logic [IDX_W-1:0] IX_RADLO  = 6'h08;
    localparam logic [IDX_W-1:0] IX_RADHI  = 6'h09;
    localparam logic [IDX_W-1:0] IX_RCLO   = 6'h0A;
    localparam logic [IDX_W-1:0] IX_RCHI   = 6'h0B;
    localparam logic [IDX_W-1:0] IX_RXCFG  = 6'h0C;
    localparam logic [IDX_W-1:0] IX_DCFG   = 6'h0E;
    localparam logic [IDX_W-1:0] IX_IMASK  = 6'h0F;
    localparam logic [IDX_W-1:0] IX_CURPG  = 6'h17;
    localparam logic [IDX_W-1:0] IX_P2STA  = 6'h21;
    localparam logic [IDX_W-1:0] IX_P2STP  = 6'h22;
    localparam int STA_BASE = 'h11;
    localparam int MC_BASE  = 'h18;

    typedef enum logic [PAGE_W-1:0] {PG_0, PG_1, PG_2, PG_3} page_e;
endpackage

// File: rtl/nic_cmd_ctrl.sv
// Command register and transmit handshake.
// Assumes one host write per cycle. Bit 2 of the command is a pending
// flag: it is set only by an accepted start and cleared only by tx_done.
module nic_cmd_ctrl
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rcnt_zero,
    input  logic              tx_done,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] tsr_q,
    output logic              tx_start,
    output logic              rst_clr_evt,
    output logic              rdc_evt,
    output logic              tx_ok_evt
);
    logic run_wr;
    logic start_ok;

    // Decode the events caused by a command write or a completion.
    always_comb begin
        run_wr      = wr_cmd && !wdata[CB_STOP];
        start_ok    = run_wr && wdata[CB_XMIT] && !cmd_q[CB_XMIT];
        rst_clr_evt = run_wr;
        rdc_evt     = run_wr && (wdata[CB_RRD] || wdata[CB_RWR]) && rcnt_zero;
        tx_ok_evt   = tx_done && cmd_q[CB_XMIT];
    end

    // Hold the command byte, the pending flag and the transmit status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_RESET;
            tsr_q    <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= start_ok;
            if (wr_cmd) begin
                cmd_q[DATA_W-1:CB_XMIT+1] <= wdata[DATA_W-1:CB_XMIT+1];
                cmd_q[CB_XMIT-1:0]        <= wdata[CB_XMIT-1:0];
            end
            if (start_ok) begin
                cmd_q[CB_XMIT] <= 1'b1;
            end else if (tx_ok_evt) begin
                cmd_q[CB_XMIT] <= 1'b0;
                tsr_q          <= TX_OK_STS;
            end
        end
    end
endmodule

// File: rtl/nic_irq_unit.sv
// Interrupt status and mask registers and the level interrupt output.
// Status bits 6:0 are write-one-to-clear. Bit 7 is the reset flag, which
// is cleared only by a run command and never reaches the output.
module nic_irq_unit
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_isr,
    input  logic              wr_imr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              clr_rst,
    output logic [DATA_W-1:0] isr_q,
    output logic              irq
);
    logic [DATA_W-1:0] imr_q;
    logic [DATA_W-1:0] clr_vec;

    // Build the clear mask from host writes and the reset-flag clear.
    always_comb begin
        clr_vec = '0;
        if (wr_isr) clr_vec[IB_RST-1:0] = wdata[IB_RST-1:0];
        if (clr_rst) clr_vec[IB_RST] = 1'b1;
    end

    // Update status (set events win over clears) and the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= 8'h80;
            imr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (wr_imr) imr_q <= wdata;
        end
    end

    assign irq = |(isr_q[IB_RST-1:0] & imr_q[IB_RST-1:0]);
endmodule

// File: rtl/nic_cfg_regs.sv
// Writable setup registers for the datapath: ring pointers, transmit
// and remote DMA fields, config bytes, station address and multicast
// filter. wr_en must already exclude offset 0 and page 3.
module nic_cfg_regs
    import nic_regs_pkg::*;
#(
    parameter int MEM_END_PG = 128,
    parameter int N_STA      = 6,
    parameter int N_MC       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           start_pg,
    output logic [DATA_W-1:0]           stop_pg,
    output logic [DATA_W-1:0]           bnd_pg,
    output logic [DATA_W-1:0]           cur_pg,
    output logic [DATA_W-1:0]           tx_pg,
    output logic [CNT_W-1:0]            tx_cnt,
    output logic [CNT_W-1:0]            rmt_addr,
    output logic [CNT_W-1:0]            rmt_cnt,
    output logic [DATA_W-1:0]           rx_cfg,
    output logic [DATA_W-1:0]           dat_cfg,
    output logic [N_STA-1:0][DATA_W-1:0] sta,
    output logic [N_MC-1:0][DATA_W-1:0]  mc
);
    logic incl_ok;
    logic excl_ok;

    // Page range checks: inclusive for start/stop, exclusive otherwise.
    always_comb begin
        incl_ok = int'(wdata) <= MEM_END_PG;
        excl_ok = int'(wdata) <  MEM_END_PG;
    end

    // Scalar and split 16-bit setup registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pg <= '0; stop_pg <= '0; bnd_pg <= '0; cur_pg <= '0;
            tx_pg    <= '0; tx_cnt  <= '0; rmt_addr <= '0; rmt_cnt <= '0;
            rx_cfg   <= '0; dat_cfg <= '0;
        end else if (wr_en) begin
            case (idx)
                IX_RSTART: if (incl_ok) start_pg <= wdata;
                IX_RSTOP:  if (incl_ok) stop_pg  <= wdata;
                IX_BNDY:   if (excl_ok) bnd_pg   <= wdata;
                IX_CURPG:  if (excl_ok) cur_pg   <= wdata;
                IX_TXPG:   tx_pg <= wdata;
                IX_TXCLO:  tx_cnt[DATA_W-1:0]       <= wdata;
                IX_TXCHI:  tx_cnt[CNT_W-1:DATA_W]   <= wdata;
                IX_RADLO:  rmt_addr[DATA_W-1:0]     <= wdata;
                IX_RADHI:  rmt_addr[CNT_W-1:DATA_W] <= wdata;
                IX_RCLO:   rmt_cnt[DATA_W-1:0]      <= wdata;
                IX_RCHI:   rmt_cnt[CNT_W-1:DATA_W]  <= wdata;
                IX_RXCFG:  rx_cfg  <= wdata;
                IX_DCFG:   dat_cfg <= wdata;
                default: ;
            endcase
        end
    end

    logic [DATA_W-1:0] sta_r [N_STA];
    logic [DATA_W-1:0] mc_r  [N_MC];

    for (genvar g = 0; g < N_STA; g++) begin : g_sta
        localparam logic [IDX_W-1:0] MY_IX = IDX_W'(STA_BASE + g);
        // One station address byte.
        always_ff @(posedge clk) begin
            if (!rst_n) sta_r[g] <= '0;
            else if (wr_en && idx == MY_IX) sta_r[g] <= wdata;
        end
        assign sta[g] = sta_r[g];
    end

    for (genvar g = 0; g < N_MC; g++) begin : g_mc
        localparam logic [IDX_W-1:0] MY_IX = IDX_W'(MC_BASE + g);
        // One multicast filter byte.
        always_ff @(posedge clk) begin
            if (!rst_n) mc_r[g] <= '0;
            else if (wr_en && idx == MY_IX) mc_r[g] <= wdata;
        end
        assign mc[g] = mc_r[g];
    end
endmodule

// File: rtl/nic_read_mux.sv
// Combinational read-back selection by register index. Locations with
// no readable register return zero.
module nic_read_mux
    import nic_regs_pkg::*;
#(
    parameter int N_STA = 6,
    parameter int N_MC  = 8
) (
    input  logic [IDX_W-1:0]             idx,
    input  logic                         is_cmd,
    input  logic [DATA_W-1:0]            cmd_q,
    input  logic [DATA_W-1:0]            tsr_q,
    input  logic [DATA_W-1:0]            isr_q,
    input  logic [DATA_W-1:0]            start_pg,
    input  logic [DATA_W-1:0]            stop_pg,
    input  logic [DATA_W-1:0]            bnd_pg,
    input  logic [DATA_W-1:0]            cur_pg,
    input  logic [CNT_W-1:0]             rmt_addr,
    input  logic [N_STA-1:0][DATA_W-1:0] sta,
    input  logic [N_MC-1:0][DATA_W-1:0]  mc,
    output logic [DATA_W-1:0]            rdata
);
    // Select the readable register at the current index.
    always_comb begin
        rdata = '0;
        case (idx)
            IX_BNDY:  rdata = bnd_pg;
            IX_TXPG:  rdata = tsr_q;
            IX_ISTAT: rdata = isr_q;
            IX_RADLO: rdata = rmt_addr[DATA_W-1:0];
            IX_RADHI: rdata = rmt_addr[CNT_W-1:DATA_W];
            IX_RCLO:  rdata = ID_BYTE0;
            IX_RCHI:  rdata = ID_BYTE1;
            IX_CURPG: rdata = cur_pg;
            IX_P2STA: rdata = start_pg;
            IX_P2STP: rdata = stop_pg;
            default: ;
        endcase
        for (int i = 0; i < N_STA; i++)
            if (idx == IDX_W'(STA_BASE + i)) rdata = sta[i];
        for (int i = 0; i < N_MC; i++)
            if (idx == IDX_W'(MC_BASE + i)) rdata = mc[i];
        if (is_cmd) rdata = cmd_q;
    end
endmodule

// File: rtl/nic_regfile.sv
// Top of the paged NIC register file. Forms the page-qualified index,
// steers writes to the command, interrupt and setup submodules, and
// returns read data. Assumes a single-cycle write strobe.
module nic_regfile
    import nic_regs_pkg::*;
#(
    parameter int MEM_END_PG = 128,
    parameter int N_STA      = 6,
    parameter int N_MC       = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       wr_en,
    output logic [DATA_W-1:0]          rdata,
    output logic                       irq,
    output logic                       tx_start,
    input  logic                       tx_done,
    output logic [DATA_W-1:0]          ring_start_pg,
    output logic [DATA_W-1:0]          ring_stop_pg,
    output logic [DATA_W-1:0]          ring_bnd_pg,
    output logic [DATA_W-1:0]          ring_cur_pg,
    output logic [DATA_W-1:0]          tx_page,
    output logic [CNT_W-1:0]           tx_count,
    output logic [CNT_W-1:0]           rmt_addr,
    output logic [CNT_W-1:0]           rmt_count,
    output logic [DATA_W-1:0]          rx_cfg,
    output logic [DATA_W-1:0]          data_cfg,
    output logic [N_STA*DATA_W-1:0]    station_addr,
    output logic [N_MC*DATA_W-1:0]     mcast_filter
);
    logic [DATA_W-1:0] cmd_q, tsr_q, isr_q, set_vec;
    logic [IDX_W-1:0]  idx;
    page_e             page;
    logic              is_cmd, wr_cmd, wr_reg;
    logic              rst_clr_evt, rdc_evt, tx_ok_evt;
    logic [N_STA-1:0][DATA_W-1:0] sta;
    logic [N_MC-1:0][DATA_W-1:0]  mc;

    // Decode page, index and write targets.
    always_comb begin
        page    = page_e'(cmd_q[DATA_W-1:DATA_W-PAGE_W]);
        idx     = {cmd_q[DATA_W-1:DATA_W-PAGE_W], addr};
        is_cmd  = addr == '0;
        wr_cmd  = wr_en && is_cmd;
        wr_reg  = wr_en && !is_cmd && page != PG_3;
        set_vec = '0;
        set_vec[IB_RDC]  = rdc_evt;
        set_vec[IB_TXOK] = tx_ok_evt;
    end

    nic_cmd_ctrl u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(wdata),
        .rcnt_zero(rmt_count == '0), .tx_done(tx_done),
        .cmd_q(cmd_q), .tsr_q(tsr_q), .tx_start(tx_start),
        .rst_clr_evt(rst_clr_evt), .rdc_evt(rdc_evt), .tx_ok_evt(tx_ok_evt)
    );

    nic_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_isr(wr_reg && idx == IX_ISTAT), .wr_imr(wr_reg && idx == IX_IMASK),
        .wdata(wdata), .set_vec(set_vec), .clr_rst(rst_clr_evt),
        .isr_q(isr_q), .irq(irq)
    );

    nic_cfg_regs #(.MEM_END_PG(MEM_END_PG), .N_STA(N_STA), .N_MC(N_MC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_reg), .idx(idx), .wdata(wdata),
        .start_pg(ring_start_pg), .stop_pg(ring_stop_pg), .bnd_pg(ring_bnd_pg),
        .cur_pg(ring_cur_pg), .tx_pg(tx_page), .tx_cnt(tx_count),
        .rmt_addr(rmt_addr), .rmt_cnt(rmt_count), .rx_cfg(rx_cfg),
        .dat_cfg(data_cfg), .sta(sta), .mc(mc)
    );

    nic_read_mux #(.N_STA(N_STA), .N_MC(N_MC)) u_rd (
        .idx(idx), .is_cmd(is_cmd), .cmd_q(cmd_q), .tsr_q(tsr_q),
        .isr_q(isr_q), .start_pg(ring_start_pg), .stop_pg(ring_stop_pg),
        .bnd_pg(ring_bnd_pg), .cur_pg(ring_cur_pg), .rmt_addr(rmt_addr),
        .sta(sta), .mc(mc), .rdata(rdata)
    );

    assign station_addr = sta;
    assign mcast_filter = mc;
endmodule

// File: rtl/nic_regfile_chk.sv
// Property checker for nic_regfile, attached with bind below.
module nic_regfile_chk #(
    parameter int MEM_END_PG = 128,
    parameter int STA_BITS   = 48,
    parameter int MC_BITS    = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          addr,
    input logic [7:0]          wdata,
    input logic                wr_en,
    input logic                irq,
    input logic                tx_start,
    input logic                tx_done,
    input logic [7:0]          cmd_q,
    input logic [7:0]          isr_q,
    input logic [7:0]          ring_bnd_pg,
    input logic [7:0]          ring_cur_pg,
    input logic [STA_BITS-1:0] station_addr,
    input logic [MC_BITS-1:0]  mcast_filter
);
    // R1
    reset_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> isr_q == 8'h80);

    // R3
    rst_bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[6:0] == 7'd0 |-> !irq);

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h7 && cmd_q[7:6] == 2'd0 && !tx_done)
        |=> (isr_q[6:0] & $past(wdata[6:0])) == 7'd0);

    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R9
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && cmd_q[2]) |=> (isr_q[1] && !cmd_q[2]));

    // R11
    bnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h3 && cmd_q[7:6] == 2'd0 && int'(wdata) >= MEM_END_PG)
        |=> $stable(ring_bnd_pg));

    // R12
    page3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != 4'h0 && cmd_q[7:6] == 2'd3)
        |=> ($stable(station_addr) && $stable(mcast_filter) && $stable(ring_cur_pg)));
endmodule

bind nic_regfile nic_regfile_chk #(
    .MEM_END_PG(MEM_END_PG), .STA_BITS(N_STA*8), .MC_BITS(N_MC*8)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .irq(irq), .tx_start(tx_start), .tx_done(tx_done), .cmd_q(cmd_q),
    .isr_q(isr_q), .ring_bnd_pg(ring_bnd_pg), .ring_cur_pg(ring_cur_pg),
    .station_addr(station_addr), .mcast_filter(mcast_filter)
);

// File: tb/sim_nic_regfile.sv
// Directed bench for nic_regfile: one task per scenario.
`timescale 1ns/1ps
module sim_nic_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        tx_done = 1'b0;
    logic [7:0]  rdata;
    logic        irq, tx_start;
    logic [7:0]  ring_start_pg, ring_stop_pg, ring_bnd_pg, ring_cur_pg, tx_page;
    logic [15:0] tx_count, rmt_addr, rmt_count;
    logic [7:0]  rx_cfg, data_cfg;
    logic [47:0] station_addr;
    logic [63:0] mcast_filter;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    nic_regfile u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .irq(irq), .tx_start(tx_start), .tx_done(tx_done),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
        .ring_bnd_pg(ring_bnd_pg), .ring_cur_pg(ring_cur_pg), .tx_page(tx_page),
        .tx_count(tx_count), .rmt_addr(rmt_addr), .rmt_count(rmt_count),
        .rx_cfg(rx_cfg), .data_cfg(data_cfg), .station_addr(station_addr),
        .mcast_filter(mcast_filter)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 cmd", 4'h0, 8'h01);
        rd_chk("R1 isr", 4'h7, 8'h80);
        chk("R1 irq", irq, 0);
        chk("R1 tx_start", tx_start, 0);
        chk("R1 outputs", {ring_start_pg, ring_stop_pg, ring_bnd_pg, ring_cur_pg,
            tx_page, rx_cfg, data_cfg}, 0);
        chk("R1 counts", {tx_count, rmt_addr, rmt_count}, 0);
        chk("R1 filters", {station_addr, mcast_filter}, 0);
    endtask

    task automatic t_reset_flag();
        wr(4'hF, 8'hFF);
        chk("R3 bit7 no irq", irq, 0);
        wr(4'h7, 8'h80);
        rd_chk("R6 bit7 not w1c", 4'h7, 8'h80);
        wr(4'h0, 8'h21);
        rd_chk("R3 stop set keeps bit7", 4'h7, 8'h80);
        wr(4'h0, 8'h22);
        rd_chk("R3 run clears bit7", 4'h7, 8'h00);
        wr(4'hF, 8'h00);
    endtask

    task automatic t_zero_len();
        wr(4'h0, 8'h0A);
        rd_chk("R4 zero count rdc", 4'h7, 8'h40);
        chk("R5 masked off", irq, 0);
        wr(4'hF, 8'h40);
        chk("R5 unmasked", irq, 1);
        wr(4'h7, 8'h40);
        rd_chk("R6 w1c", 4'h7, 8'h00);
        chk("R5 irq drops", irq, 0);
        wr(4'hA, 8'h05);
        chk("R7 rcnt lo", rmt_count, 16'h0005);
        wr(4'h0, 8'h12);
        rd_chk("R4 nonzero count", 4'h7, 8'h00);
        wr(4'hA, 8'h00);
    endtask

    task automatic t_halves();
        wr(4'h8, 8'h34);
        wr(4'h9, 8'h12);
        chk("R7 raddr", rmt_addr, 16'h1234);
        rd_chk("R7 raddr lo rd", 4'h8, 8'h34);
        rd_chk("R7 raddr hi rd", 4'h9, 8'h12);
        wr(4'h8, 8'h56);
        chk("R7 raddr lo only", rmt_addr, 16'h1256);
        wr(4'h5, 8'hEA);
        wr(4'h6, 8'h05);
        chk("R7 tcnt", tx_count, 16'h05EA);
        wr(4'h6, 8'h02);
        chk("R7 tcnt hi only", tx_count, 16'h02EA);
        wr(4'hB, 8'h01);
        chk("R7 rcnt hi", rmt_count, 16'h0100);
    endtask

    task automatic t_tx();
        wr(4'hF, 8'h02);
        wr(4'h4, 8'h40);
        chk("R2 tx page", tx_page, 8'h40);
        wr(4'h0, 8'h26);
        chk("R8 start pulse", tx_start, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", tx_start, 0);
        rd_chk("R8 pending bit", 4'h0, 8'h26);
        rd_chk("R9 tsr before", 4'h4, 8'h00);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        rd_chk("R9 tsr", 4'h4, 8'h01);
        rd_chk("R9 isr", 4'h7, 8'h02);
        rd_chk("R9 cmd self clear", 4'h0, 8'h22);
        chk("R9 irq", irq, 1);
        wr(4'h7, 8'h02);
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        rd_chk("R9 idle done isr", 4'h7, 8'h00);
        rd_chk("R9 idle done cmd", 4'h0, 8'h22);
        chk("R9 idle irq", irq, 0);
    endtask

    task automatic t_ids();
        rd_chk("R10 id0", 4'hA, 8'h50);
        rd_chk("R10 id1", 4'hB, 8'h43);
        rd_chk("R10 unimpl", 4'hD, 8'h00);
        wr(4'h0, 8'hA2);
        rd_chk("R10 page2 unimpl", 4'h5, 8'h00);
        wr(4'h0, 8'h22);
    endtask

    task automatic t_range();
        wr(4'h1, 8'h80);
        chk("R11 start at end", ring_start_pg, 8'h80);
        wr(4'h1, 8'h81);
        chk("R11 start beyond", ring_start_pg, 8'h80);
        wr(4'h2, 8'h60);
        chk("R11 stop", ring_stop_pg, 8'h60);
        wr(4'h3, 8'h7F);
        chk("R11 bnd below", ring_bnd_pg, 8'h7F);
        wr(4'h3, 8'h80);
        rd_chk("R11 bnd at end", 4'h3, 8'h7F);
        wr(4'h0, 8'h62);
        wr(4'h7, 8'h80);
        chk("R11 cur at end", ring_cur_pg, 8'h00);
        wr(4'h7, 8'h4C);
        rd_chk("R11 cur ok", 4'h7, 8'h4C);
        wr(4'h0, 8'hA2);
        rd_chk("R2 page2 start", 4'h1, 8'h80);
        rd_chk("R2 page2 stop", 4'h2, 8'h60);
    endtask

    task automatic t_pages();
        wr(4'h0, 8'h62);
        for (int i = 0; i < 6; i++) wr(4'(1 + i), 8'(8'h10 + i));
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'(8'hA0 + i));
        for (int i = 0; i < 6; i++) rd_chk("R12 sta rb", 4'(1 + i), 8'(8'h10 + i));
        for (int i = 0; i < 8; i++) rd_chk("R12 mc rb", 4'(8 + i), 8'(8'hA0 + i));
        chk("R12 sta out", station_addr, 48'h151413121110);
        chk("R12 mc out", mcast_filter, 64'hA7A6A5A4A3A2A1A0);
        wr(4'h0, 8'h22);
        rd_chk("R2 page0 offset1", 4'h1, 8'h00);
        rd_chk("R2 offset0 cmd", 4'h0, 8'h22);
        wr(4'h0, 8'hE2);
        wr(4'h1, 8'h99);
        wr(4'h7, 8'h11);
        wr(4'h8, 8'h55);
        rd_chk("R12 page3 read", 4'h1, 8'h00);
        rd_chk("R2 page3 cmd", 4'h0, 8'hE2);
        wr(4'h0, 8'h62);
        rd_chk("R12 page3 sta", 4'h1, 8'h10);
        rd_chk("R12 page3 cur", 4'h7, 8'h4C);
        rd_chk("R12 page3 mc", 4'h8, 8'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reset_flag();
        t_zero_len();
        t_halves();
        t_tx();
        t_ids();
        t_range();
        t_pages();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule